// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Frame Transmitter

This block turns a stream of 16-bit stereo PCM sample pairs into a serial S/PDIF line signal. Each stereo frame is a left subframe followed by a right subframe. Each subframe has 32 slots: a preamble, four auxiliary slots, a 20-bit audio field, and the validity, user, channel-status and parity flags. The block biphase-mark encodes every slot into two half-bit cells, which gives 64 cells per subframe and 128 cells per frame. One cell is issued on each clock cycle in which the cell-rate enable is high. At 44.1 kHz that enable runs at about 5.6 MHz.

A sample pair is taken through a valid/ready handshake once per frame, at the first cell of the left subframe. If no pair is waiting at that moment, the frame carries digital silence and a one-cycle underrun pulse is raised. A frame counter running modulo 192 selects the block-start preamble. The mute input sets the validity flag. The first auxiliary slot always makes the parity of each subframe even. As a result, every subframe ends at line level 0, the preambles can be sent as fixed cell patterns, and the parity flag is always 0.

Top module: `spdif_tx`

## Requirements
- R1: One cell is issued per clock cycle in which `cell_en` is high. `line_out` changes only on such cycles. Cells of a subframe leave in slot order, two cells per slot, and a left 64-cell subframe is always followed by a right one.
- R2: Preamble cells, in time order, are 11101000 for a block-start left subframe, 11100010 for any other left subframe and 11100100 for every right subframe.
- R3: The left subframe of frame 0 and of every 192nd frame after it carries the block-start preamble. The frame count wraps from 191 to 0.
- R4: Slot layout is as follows. Slots 4..7 are auxiliary. Slots 8..27 hold the audio field with its least significant bit first, and the sample occupies slots 12..27, with sample bit 0 in slot 12. Slot 28 is V, 29 is U, 30 is C and 31 is P. Slots 5..11, U, C and P carry 0.
- R5: Every data slot (4..31) is biphase-mark coded. Its first cell is the inverse of the cell before it, and its second cell differs from its first exactly when the slot bit is 1.
- R6: Slot 4 is chosen so that slots 4..31 hold an even number of ones. Every subframe therefore ends with a 0 cell.
- R7: V is 0 when `mute` is low and 1 when it is high. Under this coding the last eight cells of a subframe are 11001100 when valid and 01001100 when muted.
- R8: `mute` is sampled on the first cell of each subframe. A change during a subframe does not affect that subframe.
- R9: `pcm_ready` is high only in the cycle that issues the first cell of a left subframe, and only when `cell_en` is high. A pair is taken when `pcm_valid` and `pcm_ready` are both high. Sample inputs are ignored at all other times.
- R10: If `pcm_valid` is low when `pcm_ready` is high, both subframes of that frame carry a zero sample. `underrun` is then high for exactly the next cycle.
- R11: A synchronous active-low reset drives `line_out` and `underrun` to 0 and clears the frame count, so the first frame after reset starts with the block-start preamble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_en | input | 1 | Cell-rate enable, one cell per high cycle |
| pcm_valid | input | 1 | Sample pair offered |
| pcm_ready | output | 1 | Sample pair taken this cycle when valid |
| pcm_left | input | 16 | Left sample |
| pcm_right | input | 16 | Right sample |
| mute | input | 1 | Mark outgoing samples invalid |
| line_out | output | 1 | Biphase-mark serial line |
| underrun | output | 1 | One-cycle pulse when a frame starts without a sample |

## Verification
Three kinds of internal fault show at the line. A wrong cell position or side bit moves the next preamble away from its 128-cell grid, so it shows within one frame. A parity or level-tracking error leaves a subframe ending at level 1 or breaks a slot-boundary transition in that same subframe. A frame counter that wraps at the wrong count misplaces the block-start preamble, which shows by the 192nd frame. The line is decoded cell by cell rather than compared as a whole. The bench checks the preamble patterns, the transition rule, the sample bits, the flags and the parity for every subframe. It also checks that a mute change or a sample change in mid-subframe leaves the current subframe untouched.

// File: rtl/spdif_tx_pkg.sv
// Shared constants for the S/PDIF transmitter: slot layout, preamble
// cell patterns and the preamble selector type. The patterns assume the
// line sits at level 0 before the preamble, which even parity guarantees.
package spdif_tx_pkg;
    localparam int SLOTS       = 32;
    localparam int CELLS       = 2 * SLOTS;
    localparam int AUX_SLOT0   = 4;
    localparam int AUDIO_SLOT0 = 8;
    localparam int AUDIO_W     = 20;
    localparam int VFLAG_SLOT  = 28;

    localparam logic [7:0] PAT_BLOCK = 8'b1110_1000;
    localparam logic [7:0] PAT_LEFT  = 8'b1110_0010;
    localparam logic [7:0] PAT_RIGHT = 8'b1110_0100;

    typedef enum logic [1:0] {
        PRE_BLOCK = 2'd0,
        PRE_LEFT  = 2'd1,
        PRE_RIGHT = 2'd2
    } pre_kind_e;
endpackage

// File: rtl/spdif_block_ctr.sv
// Frame counter modulo FRAMES. It advances once per finished stereo frame
// and flags frame 0, which carries the block-start preamble.
// Assumes frame_done is a single-cycle pulse.
module spdif_block_ctr #(
    parameter int FRAMES = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_done,
    output logic block_start
);
    localparam int CW = $clog2(FRAMES);
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] cnt_q;

    // Count finished frames, wrapping after the last frame of a block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (frame_done)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign block_start = (cnt_q == '0);

    // R3
    wrap_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && cnt_q == LAST) |=> block_start);
endmodule

// File: rtl/spdif_sub_enc.sv
// Builds the 64 cells of one subframe from a sample, the preamble kind and
// the invalid flag. Purely combinational. The first auxiliary slot forces
// even parity, so encoding can always start from level 0 after the preamble.
module spdif_sub_enc
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  pre_kind_e           kind,
    input  logic                invalid,
    output logic [CELLS-1:0]    cells
);
    localparam int SAMPLE_SLOT0 = AUDIO_SLOT0 + AUDIO_W - SAMPLE_W;

    logic [SLOTS-1:0] slots;
    logic [7:0]       pre;
    logic             lvl;

    // Place sample and flag into slot positions, then set the parity slot.
    always_comb begin
        slots = '0;
        for (int i = 0; i < SAMPLE_W; i++)
            slots[SAMPLE_SLOT0 + i] = sample[i];
        slots[VFLAG_SLOT] = invalid;
        slots[AUX_SLOT0]  = ^slots[SLOTS-1:AUX_SLOT0+1];
    end

    // Select the preamble pattern and biphase-mark code the data slots.
    always_comb begin
        case (kind)
            PRE_BLOCK: pre = PAT_BLOCK;
            PRE_RIGHT: pre = PAT_RIGHT;
            default:   pre = PAT_LEFT;
        endcase
        cells = '0;
        cells[CELLS-1 -: 8] = pre;
        lvl = 1'b0;
        for (int s = AUX_SLOT0; s < SLOTS; s++) begin
            lvl = ~lvl;
            cells[CELLS-1-2*s] = lvl;
            if (slots[s])
                lvl = ~lvl;
            cells[CELLS-2-2*s] = lvl;
        end
    end
endmodule

// File: rtl/spdif_cell_ser.sv
// Serialises subframes one cell per enable. It loads a fresh 64-cell
// vector on the first cell of each subframe and tracks the left/right side.
// Assumes load_cells is valid in any cycle where sub_start is high.
module spdif_cell_ser
    import spdif_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cell_en,
    input  logic [CELLS-1:0] load_cells,
    output logic             line_out,
    output logic             sub_start,
    output logic             right_side,
    output logic             frame_done
);
    localparam int PW = $clog2(CELLS);
    localparam logic [PW-1:0] LAST = PW'(CELLS - 1);

    logic [PW-1:0]    pos_q;
    logic [CELLS-1:0] shreg_q;
    logic             side_q;
    logic             line_q;

    assign sub_start  = cell_en && (pos_q == '0);
    assign frame_done = cell_en && (pos_q == LAST) && side_q;
    assign right_side = side_q;
    assign line_out   = line_q;

    // Issue one cell per enable; reload at the start of every subframe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            shreg_q <= '0;
            side_q  <= 1'b0;
            line_q  <= 1'b0;
        end else if (cell_en) begin
            if (pos_q == '0) begin
                line_q  <= load_cells[CELLS-1];
                shreg_q <= {load_cells[CELLS-2:0], 1'b0};
            end else begin
                line_q  <= shreg_q[CELLS-1];
                shreg_q <= {shreg_q[CELLS-2:0], 1'b0};
            end
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
            if (pos_q == LAST)
                side_q <= ~side_q;
        end
    end

    // R1
    line_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en |=> $stable(line_q));

    // R6
    sub_ends_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_start |-> (line_q == 1'b0));
endmodule

// File: rtl/spdif_tx.sv
// S/PDIF transmitter top. It accepts one stereo pair per frame, holds the
// right sample for the second subframe, chooses the preamble and feeds the
// encoder and serialiser. Assumes cell_en runs at 128 cells per frame.
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int FRAMES   = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_en,
    input  logic                pcm_valid,
    output logic                pcm_ready,
    input  logic [SAMPLE_W-1:0] pcm_left,
    input  logic [SAMPLE_W-1:0] pcm_right,
    input  logic                mute,
    output logic                line_out,
    output logic                underrun
);
    logic [CELLS-1:0]    cells;
    logic                sub_start, right_side, frame_done, block_start;
    logic [SAMPLE_W-1:0] right_q, cur_sample;
    logic                under_q;
    pre_kind_e           kind;

    assign pcm_ready = sub_start && !right_side;
    assign underrun  = under_q;

    // Hold the right sample (or silence) and flag a missing pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            right_q <= '0;
            under_q <= 1'b0;
        end else begin
            under_q <= pcm_ready && !pcm_valid;
            if (pcm_ready)
                right_q <= pcm_valid ? pcm_right : '0;
        end
    end

    // Pick the sample and preamble for the subframe about to start.
    always_comb begin
        if (right_side) begin
            cur_sample = right_q;
            kind       = PRE_RIGHT;
        end else begin
            cur_sample = pcm_valid ? pcm_left : '0;
            kind       = block_start ? PRE_BLOCK : PRE_LEFT;
        end
    end

    spdif_sub_enc #(.SAMPLE_W(SAMPLE_W)) u_enc (
        .sample  (cur_sample),
        .kind    (kind),
        .invalid (mute),
        .cells   (cells)
    );

    spdif_cell_ser u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_en    (cell_en),
        .load_cells (cells),
        .line_out   (line_out),
        .sub_start  (sub_start),
        .right_side (right_side),
        .frame_done (frame_done)
    );

    spdif_block_ctr #(.FRAMES(FRAMES)) u_blk (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_done  (frame_done),
        .block_start (block_start)
    );

    // R9
    ready_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_ready |-> cell_en);

    // R10
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ready && !pcm_valid) |=> underrun);

    // R10
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(pcm_ready && !pcm_valid));
endmodule

// File: tb/tb_spdif_tx.sv
`timescale 1ns/1ps
module tb_spdif_tx;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0, cell_en = 1'b0, pcm_valid = 1'b0, mute = 1'b0;
    logic [15:0] pcm_left = '0, pcm_right = '0;
    logic        pcm_ready, line_out, underrun;

    int n_chk = 0, n_err = 0, fidx = 0;
    bit stable_bad = 0;

    spdif_tx dut (
        .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .pcm_valid(pcm_valid),
        .pcm_ready(pcm_ready), .pcm_left(pcm_left), .pcm_right(pcm_right),
        .mute(mute), .line_out(line_out), .underrun(underrun)
    );

    // Table entries: {valid, left, right, mute during left, mute during right}
    localparam logic [34:0] VEC [8] = '{
        {1'b1, 16'h1234, 16'hABCD, 1'b0, 1'b0},
        {1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
        {1'b1, 16'h8001, 16'h7FFE, 1'b0, 1'b0},
        {1'b0, 16'h5555, 16'h3333, 1'b0, 1'b0},
        {1'b1, 16'h5A5A, 16'hA5A5, 1'b1, 1'b1},
        {1'b1, 16'h0F0F, 16'hF0F0, 1'b0, 1'b1},
        {1'b1, 16'h0001, 16'h8000, 1'b1, 1'b0},
        {1'b1, 16'h0000, 16'hFFFF, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cell: enable for one cycle, capture, then one idle cycle checked for hold.
    task automatic send_cell(output logic c, output logic rd, output logic ur);
        @(negedge clk);
        cell_en = 1'b1;
        #1 rd = pcm_ready;
        @(negedge clk);
        c = line_out;
        ur = underrun;
        cell_en = 1'b0;
        @(negedge clk);
        if (line_out !== c) stable_bad = 1;
    endtask

    // Decode one subframe (index 63 = first cell) and check it.
    task automatic check_sub(input logic [63:0] v, input logic [7:0] pre,
                             input logic [15:0] smp, input bit vflag, input string side);
        logic prev, a, b;
        bit tr_ok = 1;
        logic [31:0] bits = '0;
        chk(v[63:56] == pre, "R2", {side, " preamble"}, 64'(v[63:56]), 64'(pre));
        prev = v[56];
        for (int s = 4; s < 32; s++) begin
            a = v[63-2*s];
            b = v[62-2*s];
            if (a == prev) tr_ok = 0;
            bits[s] = a ^ b;
            prev = b;
        end
        chk(tr_ok, "R5", {side, " slot transitions"}, 64'(tr_ok), 64'(1));
        chk(bits[27:12] == smp, "R4", {side, " sample"}, 64'(bits[27:12]), 64'(smp));
        chk(bits[11:5] == '0 && bits[31:29] == '0, "R4", {side, " zero slots"},
            64'({bits[31:29], bits[11:5]}), 64'(0));
        chk(bits[28] == vflag, "R8", {side, " V flag"}, 64'(bits[28]), 64'(vflag));
        chk((^bits[31:4]) == 1'b0 && v[0] == 1'b0, "R6", {side, " parity/end level"},
            64'({^bits[31:4], v[0]}), 64'(0));
        chk(v[7:0] == (vflag ? 8'b0100_1100 : 8'b1100_1100), "R7", {side, " flag cells"},
            64'(v[7:0]), 64'(vflag ? 8'b0100_1100 : 8'b1100_1100));
    endtask

    task automatic run_frame(input bit valid, input logic [15:0] l, input logic [15:0] r,
                             input bit ml, input bit mr);
        logic c, rd, ur, rd0, ur0;
        bit bad_rdy = 0;
        logic [63:0] vl = '0, vr = '0;
        pcm_valid = valid; pcm_left = l; pcm_right = r; mute = ml;
        for (int k = 0; k < 128; k++) begin
            send_cell(c, rd, ur);
            if (k == 0) begin
                rd0 = rd; ur0 = ur;
                pcm_valid = 1'b0; pcm_left = 16'hDEAD; pcm_right = 16'hBEEF;
            end else if (rd) begin
                bad_rdy = 1;
            end
            if (k == 20) mute = mr;
            if (k < 64) vl = {vl[62:0], c};
            else        vr = {vr[62:0], c};
        end
        chk(rd0 == 1'b1, "R9", "ready at frame start", 64'(rd0), 64'(1));
        chk(!bad_rdy, "R9", "ready elsewhere", 64'(bad_rdy), 64'(0));
        chk(ur0 == !valid, "R10", "underrun pulse", 64'(ur0), 64'(!valid));
        // R3: block-start preamble on frame 0 of every 192
        check_sub(vl, (fidx % 192 == 0) ? 8'b1110_1000 : 8'b1110_0010,
                  valid ? l : 16'h0, ml, "left");
        check_sub(vr, 8'b1110_0100, valid ? r : 16'h0, mr, "right");
        fidx++;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; cell_en = 1'b0; pcm_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R11
        chk(line_out == 1'b0 && underrun == 1'b0, "R11", "reset outputs",
            64'({line_out, underrun}), 64'(0));
        rst_n = 1'b1;
        fidx = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic c, rd, ur;
        apply_reset();
        foreach (VEC[i])
            run_frame(VEC[i][34], VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);
        // R3: run up to frame 192, which must carry the block-start preamble again
        while (fidx <= 192)
            run_frame(1'b1, 16'(fidx * 16'h0101), 16'(~fidx), 1'b0, 1'b0);
        // R11: reset in mid-frame restarts the block
        for (int k = 0; k < 40; k++) send_cell(c, rd, ur);
        apply_reset();
        run_frame(1'b1, 16'hC3C3, 16'h3C3C, 1'b0, 1'b0);
        chk(!stable_bad, "R1", "line held without enable", 64'(stable_bad), 64'(0));
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule